// File: doc/BRIEF.md
# Sequential Unsigned Divider with Fixed-Point Mode

This block divides one unsigned 32-bit operand by another over many clock cycles. It retires one quotient bit per cycle. A single-cycle start request captures three things: the numerator, the denominator and a mode select.

In whole-number mode the block returns the integer quotient and the remainder. In fixed-point mode the numerator is first extended by sixteen zero bits on the right, which gives a 48-bit numerator. The quotient then reads as a 16.16 value and is cut to its low 32 bits.

A zero denominator is not iterated. The block finishes at once, returns a quotient of all ones and keeps the previous remainder. Both results stay in output registers until the next operation finishes. The block produces no condition flags.

Top module: `seq_divider`

## Requirements
- R1: With mode_frac_i = 0 and a nonzero denominator, quotient_o = floor(numer/denom) and remainder_o = numer mod denom, both unsigned 32-bit.
- R2: With mode_frac_i = 1 and a nonzero denominator, the numerator is numer·2^16 (48 bits). quotient_o holds bits 31:0 of floor(numer·2^16/denom) and remainder_o holds numer·2^16 mod denom.
- R3: A zero denominator raises done_o on the clock edge after the one that accepts the request, without raising busy_o. quotient_o becomes 0xFFFFFFFF and remainder_o keeps its prior value.
- R4: For a nonzero denominator, busy_o is high from the edge that accepts the request. done_o rises 32 edges later in whole-number mode and 48 edges later in fixed-point mode.
- R5: done_o lasts exactly one cycle, and busy_o and done_o are never high together.
- R6: A start request while busy_o is high is ignored. The running operation keeps its operands, its mode and its timing.
- R7: Synchronous reset clears busy_o, done_o, quotient_o and remainder_o to zero.
- R8: quotient_o and remainder_o change only in the cycle where done_o is high, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| numer_i | input | 32 | Numerator (dividend) |
| denom_i | input | 32 | Denominator (divisor) |
| mode_frac_i | input | 1 | 1 selects the 16.16 fixed-point mode |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Registered quotient |
| remainder_o | output | 32 | Registered remainder |

## Verification
A bad partial remainder or a misaligned shift register is not visible while the operation runs. It shows up only in quotient_o or remainder_o in the cycle done_o rises, 32 or 48 cycles after the request.

A wrong iteration counter or a mode captured at the wrong time shows up as done_o landing on the wrong edge. The bench therefore counts cycles exactly for both modes.

A zero-denominator path that disturbs state shows up one cycle after the request, as a changed remainder_o or as a busy_o pulse.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } div_state_t;
endpackage

// File: rtl/seqdiv_ctrl.sv
module seqdiv_ctrl
  import seqdiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  localparam int WIDE_W = DATA_W + FRAC_W,
  localparam int CNT_W  = $clog2(WIDE_W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic denom_zero,
  input  logic frac,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic last,
  output logic zero_hit
);
  div_state_t       state;
  logic [CNT_W-1:0] cnt;

  localparam logic [CNT_W-1:0] N_INT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_FRAC = CNT_W'(WIDE_W);

  assign busy     = (state == S_RUN);
  assign step     = (state == S_RUN);
  assign last     = step && (cnt == CNT_W'(1));
  assign load     = (state == S_IDLE) && start && !denom_zero;
  assign zero_hit = (state == S_IDLE) && start && denom_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (zero_hit) begin
            done <= 1'b1;
          end else if (load) begin
            state <= S_RUN;
            cnt   <= frac ? N_FRAC : N_INT;
          end
        end
        default: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: never busy and done together
  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R3: zero denominator finishes on the next edge without iterating
  p_zero_fast_r3: assert property (@(posedge clk) disable iff (rst)
    zero_hit |=> done && !busy);
  // R4: an accepted request keeps the block busy on the next cycle
  p_run_starts_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/seqdiv_datapath.sv
module seqdiv_datapath #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  localparam int WIDE_W = DATA_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] numer,
  input  logic [DATA_W-1:0] denom,
  output logic [DATA_W-1:0] quo_next,
  output logic [DATA_W-1:0] rem_next
);
  logic [WIDE_W-1:0] shreg;
  logic [DATA_W-1:0] rem_q;
  logic [DATA_W-1:0] dvs_q;
  logic [DATA_W:0]   trial;
  logic [DATA_W-1:0] diff;
  logic              fits;

  // one restoring step: bring in next numerator bit, try subtract
  assign trial    = {rem_q, shreg[WIDE_W-1]};
  assign fits     = (trial >= {1'b0, dvs_q});
  assign diff     = trial[DATA_W-1:0] - dvs_q;
  assign rem_next = fits ? diff : trial[DATA_W-1:0];
  assign quo_next = {shreg[DATA_W-2:0], fits};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      // numerator left-aligned; integer mode simply stops after DATA_W steps
      shreg <= {numer, {FRAC_W{1'b0}}};
      rem_q <= '0;
      dvs_q <= denom;
    end else if (step) begin
      shreg <= {shreg[WIDE_W-2:0], fits};
      rem_q <= rem_next;
    end
  end

  // R1: partial remainder always stays below the captured denominator
  p_rem_below_denom_r1: assert property (@(posedge clk) disable iff (rst)
    step |=> rem_q < dvs_q);
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] numer_i,
  input  logic [DATA_W-1:0] denom_i,
  input  logic              mode_frac_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o
);
  logic load, step, last, zero_hit;
  logic [DATA_W-1:0] quo_next, rem_next;

  seqdiv_ctrl #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .denom_zero (denom_i == '0),
    .frac       (mode_frac_i),
    .busy       (busy_o),
    .done       (done_o),
    .load       (load),
    .step       (step),
    .last       (last),
    .zero_hit   (zero_hit)
  );

  seqdiv_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .numer    (numer_i),
    .denom    (denom_i),
    .quo_next (quo_next),
    .rem_next (rem_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient_o  <= '0;
      remainder_o <= '0;
    end else if (zero_hit) begin
      quotient_o  <= '1;
    end else if (last) begin
      quotient_o  <= quo_next;
      remainder_o <= rem_next;
    end
  end

  // R3: zero denominator gives all ones and keeps the remainder
  p_zero_result_r3: assert property (@(posedge clk) disable iff (rst)
    zero_hit |=> (quotient_o == '1) && $stable(remainder_o));
  // R6: a request during a run does not abort it
  p_ignore_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
  // R8: results move only with the completion pulse
  p_hold_quotient_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(quotient_o) |-> done_o);
  p_hold_remainder_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(remainder_o) |-> done_o);
endmodule

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] numer_i = '0;
  logic [31:0] denom_i = '0;
  logic        mode_frac_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] quotient_o, remainder_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  seq_divider dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .numer_i(numer_i),
    .denom_i(denom_i), .mode_frac_i(mode_frac_i), .busy_o(busy_o),
    .done_o(done_o), .quotient_o(quotient_o), .remainder_o(remainder_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation; checks results, latency, busy and the done pulse
  task automatic do_div(input logic [31:0] a, input logic [31:0] b,
                        input logic fr, input string req);
    logic [63:0] wide, q64, r64;
    logic [31:0] eq, er;
    int exp_lat, cyc;
    bit busy_ok;
    if (b == 0) begin
      eq = 32'hFFFF_FFFF;
      er = remainder_o;
      exp_lat = 0;
    end else begin
      wide = fr ? {16'h0, a, 16'h0} : {32'h0, a};
      q64 = wide / {32'h0, b};
      r64 = wide % {32'h0, b};
      eq = q64[31:0];
      er = r64[31:0];
      exp_lat = fr ? 48 : 32;
    end
    @(negedge clk);
    start_i = 1'b1; numer_i = a; denom_i = b; mode_frac_i = fr;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0; busy_ok = 1'b1;
    while (!done_o && cyc < 200) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == exp_lat, (b == 0) ? "R3" : "R4", "latency", 64'(cyc), 64'(exp_lat));
    chk(busy_ok, (b == 0) ? "R3" : "R4", "busy during run", 64'(busy_ok), 64'd1);
    chk(!busy_o, "R5", "busy with done", 64'(busy_o), 64'd0);
    chk(quotient_o == eq, req, "quotient", 64'(quotient_o), 64'(eq));
    chk(remainder_o == er, req, "remainder", 64'(remainder_o), 64'(er));
    @(negedge clk);
    chk(!done_o, "R5", "done pulse width", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o, "R7", "reset flags", {62'h0, busy_o, done_o}, 64'd0);
    chk(quotient_o == 0 && remainder_o == 0, "R7", "reset results",
        {quotient_o, remainder_o}, 64'd0);
  endtask

  task automatic t_ignore;
    int cyc;
    @(negedge clk);
    start_i = 1'b1; numer_i = 32'd1000; denom_i = 32'd10; mode_frac_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; numer_i = 32'd7; denom_i = 32'd0; mode_frac_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R6", "run kept after extra start",
        {62'h0, busy_o, done_o}, 64'd2);
    cyc = 5;
    while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
    chk(cyc == 32, "R6", "latency unchanged", 64'(cyc), 64'd32);
    chk(quotient_o == 32'd100 && remainder_o == 32'd0, "R6", "result of first op",
        {quotient_o, remainder_o}, {32'd100, 32'd0});
    @(negedge clk);
  endtask

  task automatic t_hold;
    logic [31:0] q0, r0;
    q0 = quotient_o; r0 = remainder_o;
    @(negedge clk);
    numer_i = 32'h1234; denom_i = 32'h0; mode_frac_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(quotient_o == q0 && remainder_o == r0, "R8", "results held while idle",
        {quotient_o, remainder_o}, {q0, r0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    do_div(32'd100, 32'd7, 1'b0, "R1");
    do_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R1");
    do_div(32'd5, 32'd9, 1'b0, "R1");
    do_div(32'hDEAD_BEEF, 32'h0001_2345, 1'b0, "R1");
    do_div(32'd1, 32'd2, 1'b1, "R2");
    do_div(32'd3, 32'd4, 1'b1, "R2");
    do_div(32'd10, 32'd3, 1'b1, "R2");
    do_div(32'hFFFF_FFFF, 32'd1, 1'b1, "R2");
    do_div(32'd100, 32'd7, 1'b0, "R1");
    do_div(32'd1234, 32'd0, 1'b0, "R3");
    do_div(32'd55, 32'd0, 1'b1, "R3");
    t_ignore();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule